// File: doc/BRIEF.md
# Dual-Threshold Bus Request Scheduler

This block decides when a FIFO that holds words for a shared system bus should ask for a bus transfer. It watches the FIFO's word count and compares it against two programmable limits. The hard limit posts a request as soon as the count is above it, whatever the bus is doing. The soft limit posts a request only while the bus has been quiet for a run of clocks. The effect is that small transfers go out when the bus is lightly loaded, and only larger ones when it is busy. A credit count from the rest of the bus interface can hold back a request that is otherwise due.

The outgoing request follows valid/ready rules. `req_valid` is the request and `req_ready` is the grant. Once raised, `req_valid` and its `req_hard` flag stay fixed until a cycle where `req_ready` is high. That cycle completes the handshake. `req_valid` then drops for at least one cycle while the thresholds are re-evaluated against the new occupancy. `req_ready` may be held high at any time, and it has no effect while `req_valid` is low.

The two limits share one 32-bit configuration word. Apart from the two threshold fields, every bit of that word reads as zero. All other pins are plain control or status signals.

Top module: `bus_req_sched`

## Requirements
- R1: A threshold is crossed only when `fifo_level` is strictly greater than it. A level equal to the threshold never posts a request.
- R2: When `fifo_level` exceeds the hard threshold and `credit` is nonzero, `req_valid` rises on the next clock edge, whether or not `bus_busy` is high.
- R3: The soft threshold posts a request only when `bus_busy` is low in the current cycle and was also low in the three cycles before it. That makes four consecutive quiet clocks.
- R4: Any cycle with `bus_busy` high restarts the quiet count from zero.
- R5: While `credit` is zero, no new request is posted, even if a threshold is crossed.
- R6: The two least significant bits of each threshold field always read as zero, and written values there are ignored. Thresholds are therefore multiples of four words.
- R7: The hard threshold occupies `cfg_wr_data`/`cfg_rd_data` bits [16+CNT_W-1:16] and the soft threshold occupies bits [CNT_W-1:0]. All other bits read as zero. A write (`cfg_wr_en` high) takes effect at the next clock edge.
- R8: Chip reset (`rst_n` low) clears the configuration word to zero. `soft_rst` leaves it unchanged.
- R9: Once raised, `req_valid` stays high and `req_hard` stays stable until a cycle with `req_ready` high. After that cycle `req_valid` is low for at least one cycle.
- R10: `soft_rst` clears any pending request and the quiet count at the next clock edge.
- R11: `req_hard` is 1 when the posted request was caused by the hard threshold. This includes the case where both thresholds are crossed at once. It is 0 for a soft-only request, and 0 whenever `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset: clears request and quiet count, keeps configuration |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write word |
| cfg_rd_data | output | 32 | Configuration read-back word |
| fifo_level | input | CNT_W | Current FIFO word count |
| bus_busy | input | 1 | High in any cycle with a bus transfer |
| credit | input | CRED_W | Enqueue credit count; zero holds off new requests |
| req_valid | output | 1 | Bus transfer request |
| req_ready | input | 1 | Grant; completes the handshake when `req_valid` is high |
| req_hard | output | 1 | Request was caused by the hard threshold |

## Verification
The occupancy is stepped through each threshold, just below it, at it and one word above it. This separates a strictly-greater compare from a greater-or-equal one. The soft path is driven with quiet runs of exactly three and exactly four clocks, and with a transfer inserted part-way through a run. These patterns distinguish the correct idle length from an off-by-one, and show whether a transfer really restarts the count. Requests are held ungranted for several cycles, granted with the level still high, blocked by zero credit, and cleared by soft reset. These cases show the hold, the post-grant gap and the hard/soft flag for each cause.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int CFG_W     = 32;
  localparam int HARD_OFS  = 16;
  localparam int SOFT_OFS  = 0;
  localparam int ALIGN_LSB = 2;
endpackage

// File: rtl/brs_thr_regs.sv
module brs_thr_regs
  import brs_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CNT_W-1:0] hard_thr,
  output logic [CNT_W-1:0] soft_thr,
  output logic [CFG_W-1:0] rd_data
);
  localparam int KEEP_W = CNT_W - ALIGN_LSB;

  logic [KEEP_W-1:0] hard_q, soft_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard_q <= '0;
      soft_q <= '0;
    end else if (wr_en) begin
      hard_q <= wr_data[HARD_OFS+ALIGN_LSB +: KEEP_W];
      soft_q <= wr_data[SOFT_OFS+ALIGN_LSB +: KEEP_W];
    end
  end

  assign hard_thr = {hard_q, {ALIGN_LSB{1'b0}}};
  assign soft_thr = {soft_q, {ALIGN_LSB{1'b0}}};

  always_comb begin
    rd_data = '0;
    rd_data[HARD_OFS +: CNT_W] = hard_thr;
    rd_data[SOFT_OFS +: CNT_W] = soft_thr;
  end
endmodule

// File: rtl/brs_idle_detect.sv
module brs_idle_detect #(
  parameter int IDLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic bus_busy,
  output logic bus_idle
);
  localparam int RUN_MAX = IDLE_CYCLES - 1;
  localparam int RUN_W   = $clog2(IDLE_CYCLES) + 1;

  logic [RUN_W-1:0] quiet_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_run <= '0;
    end else if (soft_rst || bus_busy) begin
      quiet_run <= '0;
    end else if (quiet_run < RUN_W'(RUN_MAX)) begin
      quiet_run <= quiet_run + 1'b1;
    end
  end

  assign bus_idle = !bus_busy && (quiet_run >= RUN_W'(RUN_MAX));
endmodule

// File: rtl/brs_req_ctrl.sv
module brs_req_ctrl #(
  parameter int CNT_W  = 10,
  parameter int CRED_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [CNT_W-1:0]  fifo_level,
  input  logic [CNT_W-1:0]  hard_thr,
  input  logic [CNT_W-1:0]  soft_thr,
  input  logic              bus_idle,
  input  logic [CRED_W-1:0] credit,
  input  logic              req_ready,
  output logic              req_valid,
  output logic              req_hard
);
  logic hard_due, soft_due, can_post;

  assign hard_due = fifo_level > hard_thr;
  assign soft_due = (fifo_level > soft_thr) && bus_idle;
  assign can_post = (hard_due || soft_due) && (credit != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_hard  <= 1'b0;
    end else if (soft_rst) begin
      req_valid <= 1'b0;
      req_hard  <= 1'b0;
    end else if (req_valid) begin
      if (req_ready) begin
        req_valid <= 1'b0;
        req_hard  <= 1'b0;
      end
    end else if (can_post) begin
      req_valid <= 1'b1;
      req_hard  <= hard_due;
    end
  end
endmodule

// File: rtl/bus_req_sched.sv
module bus_req_sched
  import brs_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int CRED_W      = 4,
  parameter int IDLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_wr_en,
  input  logic [31:0]       cfg_wr_data,
  output logic [31:0]       cfg_rd_data,
  input  logic [CNT_W-1:0]  fifo_level,
  input  logic              bus_busy,
  input  logic [CRED_W-1:0] credit,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_hard
);
  logic [CNT_W-1:0] hard_thr, soft_thr;
  logic             bus_idle;

  brs_thr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .hard_thr(hard_thr), .soft_thr(soft_thr), .rd_data(cfg_rd_data)
  );

  brs_idle_detect #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_busy(bus_busy),
    .bus_idle(bus_idle)
  );

  brs_req_ctrl #(.CNT_W(CNT_W), .CRED_W(CRED_W)) u_req (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fifo_level(fifo_level),
    .hard_thr(hard_thr), .soft_thr(soft_thr), .bus_idle(bus_idle),
    .credit(credit), .req_ready(req_ready), .req_valid(req_valid),
    .req_hard(req_hard)
  );
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
  parameter int CNT_W  = 10,
  parameter int CRED_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [31:0]       cfg_rd_data,
  input logic [CNT_W-1:0]  fifo_level,
  input logic              bus_busy,
  input logic [CRED_W-1:0] credit,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_hard
);
  localparam logic [31:0] FIELD    = 32'((64'(1) << CNT_W) - 64'd4);
  localparam logic [31:0] LIVE_MSK = (FIELD << 16) | FIELD;

  logic [CNT_W-1:0] hard_rd;
  assign hard_rd = cfg_rd_data[16 +: CNT_W];

  // R2, R11: level above hard threshold with credit posts a hard request
  p_hard_posts_r2: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    !req_valid && credit != '0 && fifo_level > hard_rd |=> req_valid && req_hard);

  // R3, R1: a busy cycle with level not above hard threshold posts nothing
  p_busy_blocks_soft_r3: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    !req_valid && bus_busy && fifo_level <= hard_rd |=> !req_valid);

  // R5: no credit, no new request
  p_credit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    !req_valid && credit == '0 |=> !req_valid);

  // R9: request and flag held until granted
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    req_valid && !req_ready |=> req_valid && $stable(req_hard));

  // R9: a gap follows every grant
  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);

  // R10: soft reset drops the request
  p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !req_valid);

  // R11: flag never set without a request
  p_flag_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_hard);

  // R6, R7: reserved and alignment bits read as zero
  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & ~LIVE_MSK) == 32'd0);
endmodule

bind bus_req_sched brs_checker #(.CNT_W(CNT_W), .CRED_W(CRED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_rd_data(cfg_rd_data),
  .fifo_level(fifo_level), .bus_busy(bus_busy), .credit(credit),
  .req_valid(req_valid), .req_ready(req_ready), .req_hard(req_hard)
);

// File: tb/tb_bus_req_sched.sv
module tb_bus_req_sched;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10;
  localparam int CRED_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0, soft_rst = 1'b0, cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic [CNT_W-1:0] fifo_level = '0;
  logic bus_busy = 1'b1;
  logic [CRED_W-1:0] credit = '0;
  logic req_ready = 1'b0;
  logic req_valid, req_hard;

  int checks = 0, failures = 0;
  string cur_tag = "R8";
  bit running = 1'b0;

  // behavioural reference state
  int m_hard = 0, m_soft = 0, quiet = 0;
  bit m_req = 0, m_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_req_sched #(.CNT_W(CNT_W), .CRED_W(CRED_W)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data), .fifo_level(fifo_level),
    .bus_busy(bus_busy), .credit(credit), .req_valid(req_valid),
    .req_ready(req_ready), .req_hard(req_hard)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hard = 0; m_soft = 0; quiet = 0; m_req = 0; m_flag = 0;
    end else begin
      bit idle, hd, sd;
      idle = !bus_busy && quiet >= 3;
      hd = int'(fifo_level) > m_hard;
      sd = int'(fifo_level) > m_soft && idle;
      if (soft_rst) begin m_req = 0; m_flag = 0; end
      else if (m_req) begin
        if (req_ready) begin m_req = 0; m_flag = 0; end
      end else if ((hd || sd) && credit != 0) begin
        m_req = 1; m_flag = hd;
      end
      if (soft_rst || bus_busy) quiet = 0;
      else if (quiet < 3) quiet++;
      if (cfg_wr_en) begin
        m_hard = int'(cfg_wr_data[31:16]) % 1024 / 4 * 4;
        m_soft = int'(cfg_wr_data[15:0]) % 1024 / 4 * 4;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (running) begin
    chk({cur_tag, " req_valid"}, 32'(req_valid), 32'(m_req));
    chk({cur_tag, " req_hard"}, 32'(req_hard), 32'(m_flag));
    chk({cur_tag, " cfg_rd_data"}, cfg_rd_data, 32'(m_hard << 16) | 32'(m_soft));
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    step(2);
    running = 1'b1;
    #(CLK_PERIOD/2);
    chk("R8 reset cfg", cfg_rd_data, 32'h0);
    chk("R8 reset req", 32'(req_valid), 32'h0);
    rst_n = 1'b1;
    step(1);

    cur_tag = "R7";
    cfg_wr_en = 1'b1; cfg_wr_data = 32'hFFFF_FFFF; step(1);
    cfg_wr_en = 1'b0;
    chk("R7 all-ones readback", cfg_rd_data, 32'h03FC_03FC);

    cur_tag = "R6";
    cfg_wr_en = 1'b1; cfg_wr_data = 32'h002B_000B; step(1);
    cfg_wr_en = 1'b0;
    chk("R6 low bits dropped", cfg_rd_data, 32'h0028_0008);

    // hard=40, soft=8; bus busy throughout
    cur_tag = "R1"; credit = 4'd2; bus_busy = 1'b1;
    fifo_level = 10'd8; step(3);
    cur_tag = "R3"; fifo_level = 10'd20; step(4);
    chk("R3 busy soft no req", 32'(req_valid), 32'h0);
    cur_tag = "R1"; fifo_level = 10'd40; step(3);
    chk("R1 equal hard no req", 32'(req_valid), 32'h0);

    cur_tag = "R2"; fifo_level = 10'd41; step(1);
    chk("R2 hard req next edge", 32'(req_valid), 32'h1);
    chk("R11 hard flag", 32'(req_hard), 32'h1);
    cur_tag = "R9"; step(4);
    chk("R9 held without grant", 32'(req_valid), 32'h1);
    req_ready = 1'b1; step(1);
    req_ready = 1'b0;
    chk("R9 gap after grant", 32'(req_valid), 32'h0);
    step(1);
    chk("R9 re-post after gap", 32'(req_valid), 32'h1);
    req_ready = 1'b1; fifo_level = 10'd20; step(1);
    req_ready = 1'b0;

    // soft path: quiet run of three, transfer, then four
    cur_tag = "R4";
    bus_busy = 1'b0; step(3);
    bus_busy = 1'b1; step(1);
    bus_busy = 1'b0; step(3);
    chk("R4 restart after transfer", 32'(req_valid), 32'h0);
    cur_tag = "R3"; step(1);
    chk("R3 soft req after four quiet", 32'(req_valid), 32'h1);
    chk("R11 soft flag", 32'(req_hard), 32'h0);
    req_ready = 1'b1; step(1);
    req_ready = 1'b0; step(1);
    chk("R3 soft re-post while idle", 32'(req_valid), 32'h1);
    req_ready = 1'b1; step(1); req_ready = 1'b0;

    // both crossed while idle
    cur_tag = "R11"; fifo_level = 10'd60; step(1);
    chk("R11 both crossed is hard", 32'(req_hard), 32'h1);
    req_ready = 1'b1; step(1); req_ready = 1'b0;

    cur_tag = "R5"; credit = 4'd0; step(4);
    chk("R5 zero credit holds off", 32'(req_valid), 32'h0);
    credit = 4'd1; step(1);
    chk("R5 credit releases", 32'(req_valid), 32'h1);

    cur_tag = "R10"; soft_rst = 1'b1; step(1);
    chk("R10 soft reset clears req", 32'(req_valid), 32'h0);
    chk("R8 soft reset keeps cfg", cfg_rd_data, 32'h0028_0008);
    soft_rst = 1'b0; fifo_level = 10'd20; bus_busy = 1'b0; step(3);
    chk("R10 quiet count cleared", 32'(req_valid), 32'h0);
    step(1);
    chk("R10 soft req after fresh run", 32'(req_valid), 32'h1);

    cur_tag = "R8"; rst_n = 1'b0; step(1);
    chk("R8 chip reset clears cfg", cfg_rd_data, 32'h0);
    rst_n = 1'b1; step(2);
    running = 1'b0;
    finish_run();
  end
endmodule